// File: doc/BRIEF.md
# Masked Interrupt Controller with Vector

This block gathers sixteen level-sensitive interrupt request lines from local-bus peripherals into one interrupt output for the processor. Each clock, the level of every request line is captured into a source register. A sixteen-bit enable mask selects which sources may reach the output. The output is high whenever at least one captured source is also enabled.

Software reaches the block through a small byte-wide register port. Two byte locations hold the low and high halves of the mask, and each half is written and read on its own. A vector location returns a code for the pending, enabled source with the lowest index, so a handler can branch without scanning the bits. The code is the index plus one, shifted left by two, and zero when nothing is pending. Sources 0 to 9 are wired by convention to these peripherals, in index order: parallel port, floppy, sound, video, network, SCSI, keyboard, mouse, first serial port and second serial port.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The source register captures the request lines on every rising clock edge. A change on a request line is therefore seen in the source state, and in the interrupt output, one clock after it occurs, and not before that edge.
- R2: While the synchronous reset is high, the source register and the mask register are cleared and the interrupt output is low.
- R3: After every clock edge, the interrupt output is 1 exactly when the bitwise AND of the source and mask registers is nonzero.
- R4: A read at byte offset 0 returns ((n+1) << 2), where n is the lowest index that is both pending and enabled. Index 4 alone gives 0x14. Indices 5 and 15 together give 0x18. Index 15 alone gives 0x40.
- R5: A read at byte offset 0 returns 0 when no source is both pending and enabled, including when sources are pending but masked.
- R6: A write at byte offset 2 loads mask bits 7:0 from the write data and leaves mask bits 15:8 unchanged.
- R7: A write at byte offset 3 loads mask bits 15:8 from the write data and leaves mask bits 7:0 unchanged.
- R8: Reads at byte offsets 2 and 3 return mask bits 7:0 and 15:8 respectively.
- R9: Reads at any offset other than 0, 2 and 3 return 0. Writes to any offset other than 2 and 3, including offset 0, change neither the mask nor the output.
- R10: Reading the vector has no side effect. Repeated reads return the same code, and the output stays the same while the request lines stay the same.
- R11: A mask write changes the interrupt output in the clock that follows the write edge. Clearing the only enabled pending bit drops the output, and enabling a pending bit raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | Level-sensitive interrupt request lines, bit n is source n |
| we_i | input | 1 | Register write strobe, sampled on the clock edge |
| addr_i | input | 4 | Byte offset for both read and write |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte, combinational from addr_i and register state |
| irq_o | output | 1 | Registered combined interrupt output |

## Verification
On every clock, the embedded assertions check several properties. The output must agree with the AND of the captured source and mask state. The source state must equal the request lines of the cycle before. Each mask byte lane must hold its value unless its own offset is written, and writes to other offsets must leave the mask alone. The vector read must be zero when nothing is enabled and pending, and a nonzero multiple of four when something is. Only the bench scenarios can show other behaviour. These are the exact vector codes and the lowest-index choice among several pending sources. They also cover the edge on which a request or mask change reaches the output, and that back-to-back vector reads leave the state untouched. The bench compares every cycle against a behavioural model and adds targeted probes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Byte offsets of the register port; the mask lanes follow from MASK_BASE upward.
  localparam int unsigned VEC_OFS   = 0;
  localparam int unsigned MASK_BASE = 2;
  localparam int unsigned LANE_W    = 8;
endpackage

// File: rtl/irqc_src_reg.sv
module irqc_src_reg #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] src_o
);
  logic [NUM_SRC-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= req_i;
  end

  assign src_o = src_q;

  // R1: captured state equals the request levels of the previous cycle
  p_src_follow_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> src_q == $past(req_i));
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [LANE_W-1:0]  wdata_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] mask_nxt_o
);
  localparam int unsigned LANES = NUM_SRC / LANE_W;

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_OFS = ADDR_W'(MASK_BASE + g);
    logic hit;
    assign hit = we_i && (addr_i == LANE_OFS);
    assign mask_d[g*LANE_W +: LANE_W] = hit ? wdata_i : mask_q[g*LANE_W +: LANE_W];

    // R6/R7: a lane keeps its value unless its own offset is written
    p_lane_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !(we_i && addr_i == LANE_OFS) |=> $stable(mask_q[g*LANE_W +: LANE_W]));
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  assign mask_o     = mask_q;
  assign mask_nxt_o = mask_d;
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned VEC_W   = 8
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [VEC_W-1:0]   vec_o
);
  // Scan from the top down so the lowest pending index is the last to assign.
  always_comb begin
    vec_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = VEC_W'((i + 1) * 4);
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               irq_o
);
  localparam int unsigned LANES = NUM_SRC / LANE_W;
  localparam logic [ADDR_W-1:0] VEC_A   = ADDR_W'(VEC_OFS);
  localparam logic [ADDR_W-1:0] MLO_A   = ADDR_W'(MASK_BASE);
  localparam logic [ADDR_W-1:0] MHI_A   = ADDR_W'(MASK_BASE + LANES - 1);

  logic [NUM_SRC-1:0] src_q, mask_q, mask_nxt, pend;
  logic [7:0]         vec;
  logic               irq_q;

  irqc_src_reg #(.NUM_SRC(NUM_SRC)) u_src (
    .clk(clk), .rst(rst), .req_i(req_i), .src_o(src_q)
  );

  irqc_mask_reg #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_mask (
    .clk(clk), .rst(rst), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .mask_o(mask_q), .mask_nxt_o(mask_nxt)
  );

  assign pend = src_q & mask_q;

  irqc_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(8)) u_enc (
    .pend_i(pend), .vec_o(vec)
  );

  // Output register fed from next-state values so it lines up with src_q/mask_q.
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(req_i & mask_nxt);
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == VEC_A) rdata_o = vec;
    for (int g = 0; g < int'(LANES); g++) begin
      if (addr_i == ADDR_W'(MASK_BASE + g)) rdata_o = mask_q[g*LANE_W +: LANE_W];
    end
  end

  p_reset_clear_r2: assert property (@(posedge clk)
    rst |=> (src_q == '0 && mask_q == '0 && !irq_o));

  p_irq_match_r3: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(src_q & mask_q)));

  p_vec_code_r4: assert property (@(posedge clk) disable iff (rst)
    (addr_i == VEC_A && |pend) |-> (rdata_o != 8'd0 && rdata_o[1:0] == 2'b00));

  p_vec_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (addr_i == VEC_A && pend == '0) |-> rdata_o == 8'd0);

  p_ignored_write_r9: assert property (@(posedge clk) disable iff (rst)
    (we_i && (addr_i < MLO_A || addr_i > MHI_A)) |=> $stable(mask_q));
endmodule

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vec_ctrl u_irq_vec_ctrl (
    .clk(clk), .rst(rst), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // Behavioural reference model
  logic [15:0] m_src = '0, m_mask = '0;
  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_src <= '0; m_mask <= '0;
    end else begin
      m_src <= req;
      if (we && addr == 4'd2) m_mask[7:0]  <= wdata;
      if (we && addr == 4'd3) m_mask[15:8] <= wdata;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    logic [15:0] p;
    p = m_src & m_mask;
    if (a == 4'd2) return m_mask[7:0];
    if (a == 4'd3) return m_mask[15:8];
    if (a != 4'd0) return 8'd0;
    for (int i = 0; i < 16; i++) if (p[i]) return 8'((i + 1) * 4);
    return 8'd0;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R3 irq vs model", 16'(irq), 16'(|(m_src & m_mask)));
      if (addr == 4'd0)                     chk("R4/R5 vector vs model", 16'(rdata), 16'(exp_rd(addr)));
      else if (addr == 4'd2 || addr == 4'd3) chk("R8 mask readback vs model", 16'(rdata), 16'(exp_rd(addr)));
      else                                   chk("R9 unmapped read vs model", 16'(rdata), 16'(exp_rd(addr)));
    end
  end

  task automatic set_req(input logic [15:0] r);
    @(negedge clk); #1 req = r;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); #1 we = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1 we = 1'b0; addr = 4'd0;
  endtask

  task automatic probe(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); #1 we = 1'b0; addr = a;
    #2 chk(tag, 16'(rdata), 16'(exp));
  endtask

  task automatic irq_is(input logic exp, input string tag);
    @(negedge clk); #3 chk(tag, 16'(irq), 16'(exp));
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    irq_is(1'b0, "R2 irq low after reset");
    probe(4'd2, 8'h00, "R2 mask low cleared");
    probe(4'd3, 8'h00, "R2 mask high cleared");

    set_req(16'h0010);
    irq_is(1'b0, "R3 pending but masked");
    probe(4'd0, 8'h00, "R5 masked source gives zero vector");

    wr(4'd2, 8'h30);
    probe(4'd2, 8'h30, "R6 low byte loaded");
    probe(4'd3, 8'h00, "R6 high byte unchanged");
    irq_is(1'b1, "R11 enable raises irq");
    probe(4'd0, 8'h14, "R4 index 4 code");

    wr(4'd3, 8'h81);
    probe(4'd3, 8'h81, "R7 high byte loaded");
    probe(4'd2, 8'h30, "R7 low byte unchanged");

    set_req(16'h8020);
    probe(4'd0, 8'h18, "R4 lowest index 5 wins over 15");
    set_req(16'h8000);
    probe(4'd0, 8'h40, "R4 index 15 code");
    set_req(16'h0100);
    probe(4'd0, 8'h24, "R4 index 8 code");

    // R1: request drop reaches the output only after the next edge
    @(negedge clk); #1 req = 16'h0000;
    #2 chk("R1 irq held before edge", 16'(irq), 16'h1);
    @(negedge clk); #3 chk("R1 irq follows after edge", 16'(irq), 16'h0);
    probe(4'd0, 8'h00, "R5 nothing pending");

    wr(4'd0, 8'hFF);
    wr(4'd1, 8'hFF);
    wr(4'd4, 8'hFF);
    wr(4'd15, 8'hFF);
    probe(4'd2, 8'h30, "R9 ignored writes keep low byte");
    probe(4'd3, 8'h81, "R9 ignored writes keep high byte");
    probe(4'd1, 8'h00, "R9 offset 1 reads zero");
    probe(4'd7, 8'h00, "R9 offset 7 reads zero");

    set_req(16'h0020);
    for (int k = 0; k < 5; k++) begin
      probe(4'd0, 8'h18, "R10 repeated vector read");
      chk("R10 irq unchanged by reads", 16'(irq), 16'h1);
    end

    wr(4'd2, 8'h00);
    irq_is(1'b0, "R11 clearing enable drops irq");
    probe(4'd0, 8'h00, "R5 pending source disabled");

    wr(4'd2, 8'hFF);
    @(negedge clk); #1 rst = 1'b1;
    irq_is(1'b0, "R2 reset drops irq");
    probe(4'd2, 8'h00, "R2 reset clears mask");
    @(negedge clk); #1 rst = 1'b0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule